// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This engine performs one atomic memory update at a time on behalf of a load/store unit. A request carries a base register value, a signed 16-bit displacement, an access size, an 8-bit operation code, the source register value and the value of R0. The engine computes the target address and takes a lock on a synchronous request/acknowledge memory port. It reads the old value and, when the operation calls for it, writes a new value under the same lock. It then releases the lock and returns writeback data with separate write enables for the source register and for R0.

The supported operations are add, or, and, xor, exchange and compare-and-exchange. Opcode bit 0 asks for the old memory value to be returned into the source register. Compare-and-exchange uses R0 as its comparand and always returns the old value into R0. Requests with an unsupported size or operation code are refused with a one-cycle flag and never reach memory. While an operation is in flight the engine reports busy and ignores new requests.

Top module: `amo_engine`

## Requirements
- R1: Every memory request of an operation uses the address base + sign-extended 16-bit offset, and that address stays fixed while the engine is busy.
- R2: The size code is 2'd0 for 32 bits and 2'd3 for 64 bits. Codes 2'd1 and 2'd2 raise `illegal_o` for one cycle, with no memory access and no writeback.
- R3: The only accepted operation codes are 0x00, 0x01 (add), 0x40, 0x41 (or), 0x50, 0x51 (and), 0xa0, 0xa1 (xor), 0xe1 (exchange) and 0xf1 (compare-and-exchange). Any other code is refused as in R2.
- R4: Add, or, and and xor write old value OP source back to the same address. A 32-bit access carries its data in bits 31:0 of the memory data buses, computes on those bits only, and drives bits 63:32 of the write data to zero.
- R5: When opcode bit 0 is set on add, or, and, xor or exchange, the writeback sets `wb_src_we_o` with the pre-update memory value. When bit 0 is clear, no register write enable is raised, but `wb_valid_o` still pulses once.
- R6: Exchange writes the source value to memory and returns the old value to the source register.
- R7: Compare-and-exchange writes the source value only when the old value equals R0 (low 32 bits in 32-bit mode). In both outcomes it raises `wb_r0_we_o` with the old value and leaves the source register unwritten.
- R8: `mem_lock_o` rises with the read request and stays high without a gap until the final acknowledge (the write acknowledge, or the read acknowledge when no write follows). It is low in the writeback cycle.
- R9: After reset the engine is idle. `busy_o` is high from the cycle after acceptance through the writeback cycle, and requests presented while busy are ignored.
- R10: In 32-bit mode, bits 63:32 of the read data are discarded, so the returned old value is zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_base_i | input | 64 | Base register value |
| req_offset_i | input | 16 | Signed displacement |
| req_size_i | input | 2 | Access size code |
| req_op_i | input | 8 | Operation code |
| req_src_i | input | 64 | Source register value |
| req_r0_i | input | 64 | R0 value (comparand) |
| busy_o | output | 1 | Operation in flight |
| illegal_o | output | 1 | One-cycle refusal flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_lock_o | output | 1 | Exclusive lock on memory |
| mem_dword_o | output | 1 | Access is 64 bits |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 64 | Memory read data, valid with ack |
| wb_valid_o | output | 1 | Writeback cycle |
| wb_src_we_o | output | 1 | Write enable for source register |
| wb_src_data_o | output | 64 | Data for source register |
| wb_r0_we_o | output | 1 | Write enable for R0 |
| wb_r0_data_o | output | 64 | Data for R0 |

## Verification
The assertions assume that the memory side raises `mem_ack_i` only while `mem_req_o` is high, for a single cycle per request, and that reset starts the engine idle. The bench memory model acknowledges only a pending request, after a random wait of zero to two cycles. It drops the acknowledge in the following cycle before it looks at a new request, and it puts random bits into the upper half of 32-bit read data so that zero extension is exercised. Stimulus mixes legal and illegal opcodes and sizes, compare-and-exchange operands that match and that differ, and strobes issued while the engine is busy.

// File: rtl/amo_pkg.sv
`timescale 1ns/1ps
package amo_pkg;
  typedef enum logic [2:0] {
    AMO_ADD, AMO_OR, AMO_AND, AMO_XOR, AMO_XCHG, AMO_CAS
  } amo_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_WB} amo_state_e;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  // operation base codes with the fetch bit cleared
  localparam logic [7:0] OPB_ADD  = 8'h00;
  localparam logic [7:0] OPB_OR   = 8'h40;
  localparam logic [7:0] OPB_AND  = 8'h50;
  localparam logic [7:0] OPB_XOR  = 8'ha0;
  localparam logic [7:0] OPB_XCHG = 8'he0;
  localparam logic [7:0] OPB_CAS  = 8'hf0;
endpackage

// File: rtl/amo_decode.sv
`timescale 1ns/1ps
module amo_decode
  import amo_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int SIZE_W = 2
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  output amo_kind_e         kind_o,
  output logic              fetch_o,
  output logic              dword_o,
  output logic              legal_o
);
  logic [OP_W-1:0] base;
  logic            op_ok;
  logic            size_ok;

  assign fetch_o = op_i[0];
  assign base    = {op_i[OP_W-1:1], 1'b0};
  assign dword_o = (size_i == SIZE_W'(SZ_DWORD));
  assign size_ok = dword_o || (size_i == SIZE_W'(SZ_WORD));

  always_comb begin
    kind_o = AMO_ADD;
    op_ok  = 1'b0;
    unique case (base)
      OP_W'(OPB_ADD):  begin kind_o = AMO_ADD;  op_ok = 1'b1;    end
      OP_W'(OPB_OR):   begin kind_o = AMO_OR;   op_ok = 1'b1;    end
      OP_W'(OPB_AND):  begin kind_o = AMO_AND;  op_ok = 1'b1;    end
      OP_W'(OPB_XOR):  begin kind_o = AMO_XOR;  op_ok = 1'b1;    end
      // complex operations exist only with the fetch bit set
      OP_W'(OPB_XCHG): begin kind_o = AMO_XCHG; op_ok = fetch_o; end
      OP_W'(OPB_CAS):  begin kind_o = AMO_CAS;  op_ok = fetch_o; end
      default:         begin kind_o = AMO_ADD;  op_ok = 1'b0;    end
    endcase
  end

  assign legal_o = op_ok && size_ok;
endmodule

// File: rtl/amo_alu.sv
`timescale 1ns/1ps
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_kind_e         kind_i,
  input  logic              dword_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] r0_i,
  output logic [DATA_W-1:0] new_o,
  output logic              match_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (kind_i)
      AMO_ADD: raw = old_i + src_i;
      AMO_OR:  raw = old_i | src_i;
      AMO_AND: raw = old_i & src_i;
      AMO_XOR: raw = old_i ^ src_i;
      default: raw = src_i;  // exchange and compare-and-exchange
    endcase
  end

  // narrow mode: result confined to the low half
  assign new_o   = dword_i ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
  assign match_o = dword_i ? (old_i == r0_i)
                           : (old_i[HALF_W-1:0] == r0_i[HALF_W-1:0]);
endmodule

// File: rtl/amo_engine.sv
`timescale 1ns/1ps
module amo_engine
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 8,
  parameter int SIZE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DATA_W-1:0] req_base_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [DATA_W-1:0] req_src_i,
  input  logic [DATA_W-1:0] req_r0_i,
  output logic              busy_o,
  output logic              illegal_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic              mem_dword_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic              wb_src_we_o,
  output logic [DATA_W-1:0] wb_src_data_o,
  output logic              wb_r0_we_o,
  output logic [DATA_W-1:0] wb_r0_data_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - OFF_W;

  amo_state_e        state_q, state_d;
  amo_kind_e         kind_q, dec_kind;
  logic              fetch_q, dword_q, illegal_q;
  logic              dec_fetch, dec_dword, dec_legal;
  logic [DATA_W-1:0] addr_q, src_q, r0_q, old_q;
  logic [DATA_W-1:0] eff_addr, rd_ext, alu_old, new_val;
  logic              match, accept;

  amo_decode #(.OP_W(OP_W), .SIZE_W(SIZE_W)) i_decode (
    .op_i    (req_op_i),
    .size_i  (req_size_i),
    .kind_o  (dec_kind),
    .fetch_o (dec_fetch),
    .dword_o (dec_dword),
    .legal_o (dec_legal)
  );

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign eff_addr = req_base_i + {{EXT_W{req_offset_i[OFF_W-1]}}, req_offset_i};
  assign rd_ext   = dword_q ? mem_rdata_i : {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]};
  // compare on live read data in the read cycle, on the held copy afterwards
  assign alu_old  = (state_q == ST_RD) ? rd_ext : old_q;

  amo_alu #(.DATA_W(DATA_W)) i_alu (
    .kind_i  (kind_q),
    .dword_i (dword_q),
    .old_i   (alu_old),
    .src_i   (src_q),
    .r0_i    (r0_q),
    .new_o   (new_val),
    .match_o (match)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && dec_legal) state_d = ST_RD;
      ST_RD:   if (mem_ack_i) state_d = (kind_q == AMO_CAS && !match) ? ST_WB : ST_WR;
      ST_WR:   if (mem_ack_i) state_d = ST_WB;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= AMO_ADD;
      fetch_q   <= 1'b0;
      dword_q   <= 1'b0;
      illegal_q <= 1'b0;
      addr_q    <= '0;
      src_q     <= '0;
      r0_q      <= '0;
      old_q     <= '0;
    end else begin
      state_q   <= state_d;
      illegal_q <= accept && !dec_legal;
      if (accept && dec_legal) begin
        kind_q  <= dec_kind;
        fetch_q <= dec_fetch;
        dword_q <= dec_dword;
        addr_q  <= eff_addr;
        src_q   <= req_src_i;
        r0_q    <= req_r0_i;
      end
      if (state_q == ST_RD && mem_ack_i) old_q <= rd_ext;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign illegal_o   = illegal_q;
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_lock_o  = mem_req_o;
  assign mem_dword_o = dword_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_val;

  assign wb_valid_o    = (state_q == ST_WB);
  assign wb_src_we_o   = wb_valid_o && fetch_q && (kind_q != AMO_CAS);
  assign wb_src_data_o = old_q;
  assign wb_r0_we_o    = wb_valid_o && (kind_q == AMO_CAS);
  assign wb_r0_data_o  = old_q;
endmodule

// File: rtl/amo_engine_chk.sv
`timescale 1ns/1ps
module amo_engine_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              illegal_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_lock_o,
  input logic              mem_dword_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              wb_valid_o,
  input logic              wb_src_we_o,
  input logic [DATA_W-1:0] wb_src_data_o,
  input logic              wb_r0_we_o
);
  localparam int HALF_W = DATA_W / 2;

  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));

  a_r2_illegal_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !mem_req_o && !wb_valid_o);

  a_r4_narrow_wdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_dword_o |-> mem_wdata_o[DATA_W-1:HALF_W] == '0);

  a_r5_we_in_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_src_we_o || wb_r0_we_o |-> wb_valid_o);

  a_r7_cas_r0_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_r0_we_o |-> !wb_src_we_o);

  a_r8_write_after_locked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> $past(mem_lock_o));

  a_r8_release_at_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> wb_valid_o);

  a_r9_req_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o || wb_valid_o |-> busy_o);

  a_r10_zext_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_src_we_o && !mem_dword_o |-> wb_src_data_o[DATA_W-1:HALF_W] == '0);
endmodule

bind amo_engine amo_engine_chk #(.DATA_W(DATA_W)) i_amo_engine_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .illegal_o     (illegal_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_lock_o    (mem_lock_o),
  .mem_dword_o   (mem_dword_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .wb_valid_o    (wb_valid_o),
  .wb_src_we_o   (wb_src_we_o),
  .wb_src_data_o (wb_src_data_o),
  .wb_r0_we_o    (wb_r0_we_o)
);

// File: tb/test_amo_engine.sv
`timescale 1ns/1ps
module test_amo_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_base_i = '0;
  logic [15:0] req_offset_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [7:0]  req_op_i = '0;
  logic [63:0] req_src_i = '0;
  logic [63:0] req_r0_i = '0;
  logic        busy_o, illegal_o, mem_req_o, mem_we_o, mem_lock_o, mem_dword_o;
  logic [63:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        wb_valid_o, wb_src_we_o, wb_r0_we_o;
  logic [63:0] wb_src_data_o, wb_r0_data_o;

  always #2.5 clk_i = ~clk_i;

  amo_engine i_amo_engine (.*);

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [63:0] mem [16];
  logic [63:0] shadow [16];
  logic [63:0] exp_addr = '0;
  int          n_rd = 0, n_wr = 0, addr_err = 0, lock_err = 0;
  int          stall = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // memory responder: one-cycle ack after a random wait of 0..2 cycles
  always @(negedge clk_i) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      stall = 0;
    end else if (mem_req_o) begin
      if (!mem_lock_o) lock_err++;
      if (stall >= 2 || ($urandom % 3) == 0) begin
        if (mem_addr_o != exp_addr) addr_err++;
        if (mem_we_o) begin
          n_wr++;
          if (mem_dword_o) mem[mem_addr_o[6:3]] = mem_wdata_o;
          else if (mem_addr_o[2]) mem[mem_addr_o[6:3]][63:32] = mem_wdata_o[31:0];
          else mem[mem_addr_o[6:3]][31:0] = mem_wdata_o[31:0];
        end else begin
          n_rd++;
          if (mem_dword_o) mem_rdata_i = mem[mem_addr_o[6:3]];
          else if (mem_addr_o[2]) mem_rdata_i = {$urandom, mem[mem_addr_o[6:3]][63:32]};
          else mem_rdata_i = {$urandom, mem[mem_addr_o[6:3]][31:0]};
        end
        mem_ack_i = 1'b1;
      end else begin
        stall++;
      end
    end
  end

  function automatic bit op_is_legal(input logic [7:0] op);
    return op inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1};
  endfunction

  function automatic logic [63:0] model_new(input logic [7:0] op, input logic [63:0] old,
                                            input logic [63:0] src, input bit dw);
    logic [63:0] r;
    case ({op[7:1], 1'b0})
      8'h00: r = old + src;
      8'h40: r = old | src;
      8'h50: r = old & src;
      8'ha0: r = old ^ src;
      default: r = src;
    endcase
    return dw ? r : {32'h0, r[31:0]};
  endfunction

  task automatic do_op(input logic [7:0] op, input logic [1:0] sz, input int idx, input bit hi,
                       input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0,
                       input bit poke);
    bit          dw, legal, is_cas, is_xchg, wr, got_wb, got_ill;
    logic [63:0] tgt, old, nv;
    logic        s_we, r_we;
    logic [63:0] s_d, r_d;
    dw      = (sz == 2'd3);
    legal   = op_is_legal(op) && (sz == 2'd0 || sz == 2'd3);
    is_cas  = (op == 8'hf1);
    is_xchg = (op == 8'he1);
    tgt     = 64'h1000_0000 + 64'(idx * 8) + ((!dw && hi) ? 64'd4 : 64'd0);
    exp_addr = tgt;
    if (dw) old = shadow[idx];
    else old = hi ? {32'h0, shadow[idx][63:32]} : {32'h0, shadow[idx][31:0]};
    wr = legal && (!is_cas || (dw ? old == r0 : old[31:0] == r0[31:0]));
    nv = model_new(op, old, src, dw);
    if (wr) begin
      if (dw) shadow[idx] = nv;
      else if (hi) shadow[idx][63:32] = nv[31:0];
      else shadow[idx][31:0] = nv[31:0];
    end
    n_rd = 0; n_wr = 0; addr_err = 0; lock_err = 0;
    got_wb = 1'b0; got_ill = 1'b0;
    s_we = 0; r_we = 0; s_d = '0; r_d = '0;

    @(negedge clk_i);
    req_valid_i  = 1'b1;
    req_op_i     = op;
    req_size_i   = sz;
    req_base_i   = tgt - {{48{off[15]}}, off};
    req_offset_i = off;
    req_src_i    = src;
    req_r0_i     = r0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (legal) check(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'd1);
    if (poke && legal) begin
      // competing request while busy: illegal code that must not be seen
      req_valid_i = 1'b1;
      req_op_i    = 8'h33;
      req_size_i  = 2'd1;
    end
    for (int k = 0; k < 60; k++) begin
      if (wb_valid_o || illegal_o) break;
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    req_valid_i = 1'b0;
    got_wb  = wb_valid_o;
    got_ill = illegal_o;
    s_we = wb_src_we_o; s_d = wb_src_data_o;
    r_we = wb_r0_we_o;  r_d = wb_r0_data_o;

    if (!legal) begin
      check(got_ill, "R2/R3 illegal flag", 64'(got_ill), 64'd1);
      check(!got_wb, "R2/R3 no writeback", 64'(got_wb), 64'd0);
      check(n_rd + n_wr == 0, "R2/R3 no memory access", 64'(n_rd + n_wr), 64'd0);
      @(negedge clk_i);
      check(!illegal_o, "R2 illegal flag one cycle", 64'(illegal_o), 64'd0);
    end else begin
      check(got_wb && !got_ill, "R9 writeback reached", 64'(got_wb), 64'd1);
      check(n_rd == 1, "R8 single locked read", 64'(n_rd), 64'd1);
      check(n_wr == (wr ? 1 : 0), is_cas ? "R7 compare write count" : "R4 write count",
            64'(n_wr), 64'(wr));
      check(addr_err == 0, "R1 effective address", 64'(addr_err), 64'd0);
      check(lock_err == 0, "R8 lock with request", 64'(lock_err), 64'd0);
      check(mem[idx] == shadow[idx], is_xchg ? "R6 exchange memory" :
            (dw ? "R4 memory result" : "R10 narrow memory result"), mem[idx], shadow[idx]);
      check(s_we == (op[0] && !is_cas), is_cas ? "R7 source untouched" : "R5 source enable",
            64'(s_we), 64'(op[0] && !is_cas));
      if (s_we) check(s_d == old, is_xchg ? "R6 exchange old value" : "R10 fetched old value",
                      s_d, old);
      check(r_we == is_cas, "R7 r0 enable", 64'(r_we), 64'(is_cas));
      if (r_we) check(r_d == old, "R7 r0 old zero-extended", r_d, old);
      @(negedge clk_i);
      check(!busy_o && !wb_valid_o, "R9 idle after writeback", 64'({busy_o, wb_valid_o}), 64'd0);
      check(!illegal_o, "R9 busy request ignored", 64'(illegal_o), 64'd0);
      check(!mem_lock_o, "R8 lock released", 64'(mem_lock_o), 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", n_checks);
    finish_run();
  end

  initial begin
    logic [7:0] ops [10];
    void'($urandom(32'h5eed_1234));
    ops = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1};
    for (int i = 0; i < 16; i++) begin
      mem[i] = {$urandom, $urandom};
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk_i);
    check(!busy_o && !mem_req_o && !wb_valid_o && !illegal_o && !mem_lock_o,
          "R9 reset state", 64'({busy_o, mem_req_o, wb_valid_o, illegal_o, mem_lock_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    do_op(8'h01, 2'd3, 1, 0, 16'hfff8, 64'hffff_ffff_ffff_ffff, 64'h0, 0);      // R4 wrap, negative offset
    do_op(8'h01, 2'd0, 2, 1, 16'h0010, 64'h0000_0000_ffff_ffff, 64'h0, 0);      // R10 narrow wrap
    do_op(8'h00, 2'd1, 3, 0, 16'h0, 64'h1, 64'h0, 0);                          // R2 half size
    do_op(8'h00, 2'd2, 3, 0, 16'h0, 64'h1, 64'h0, 0);                          // R2 byte size
    do_op(8'he0, 2'd3, 3, 0, 16'h0, 64'h1, 64'h0, 0);                          // R3 exchange without fetch
    do_op(8'hf0, 2'd3, 3, 0, 16'h0, 64'h1, 64'h0, 0);                          // R3 compare without fetch
    do_op(8'h02, 2'd0, 3, 0, 16'h0, 64'h1, 64'h0, 0);                          // R3 unknown code
    do_op(8'hf1, 2'd3, 4, 0, 16'h7ff0, 64'h1234, shadow[4], 0);                // R7 match
    do_op(8'hf1, 2'd3, 4, 0, 16'h0, 64'h5678, 64'h1234 ^ 64'h1, 0);           // R7 mismatch
    do_op(8'hf1, 2'd0, 5, 0, 16'h0, 64'hdead, {32'hffff_ffff, shadow[5][31:0]}, 0); // R7 narrow match
    do_op(8'he1, 2'd0, 6, 1, 16'h8000, 64'hcafe_f00d_1111_2222, 64'h0, 1);     // R6 + R9 poke
    do_op(8'h50, 2'd3, 7, 0, 16'h0, 64'h0f0f_0f0f_0f0f_0f0f, 64'h0, 1);       // R5 no fetch

    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [7:0]  op;
      logic [1:0]  sz;
      int          idx;
      bit          hi;
      logic [63:0] r0;
      op  = ($urandom % 8 == 0) ? 8'($urandom) : ops[$urandom % 10];
      sz  = ($urandom % 8 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'd3 : 2'd0);
      idx = int'($urandom % 16);
      hi  = 1'($urandom);
      r0  = {$urandom, $urandom};
      if ($urandom % 2) begin
        if (sz == 2'd3) r0 = shadow[idx];
        else r0[31:0] = hi ? shadow[idx][63:32] : shadow[idx][31:0];
      end
      do_op(op, sz, idx, hi, 16'($urandom), {$urandom, $urandom}, r0, ($urandom % 4) == 0);
    end
    finish_run();
  end
endmodule